// File: doc/BRIEF.md
# I2C Bus Divider Search Engine

This block chooses the two clock-division counts that an I2C master uses to derive its bus clock. It takes a source clock rate and a wanted bus rate, both in kHz. After a one-cycle request it runs a bounded search over candidate sample counts. The search keeps the cheapest pair of sample count and step count that reaches the required division. It then confirms that the bus rate produced by that pair does not exceed the wanted rate.

The result is reported through a one-cycle `done` pulse. Alongside the pulse come a status code, a high-speed flag and two 16-bit timing words ready for a bus controller to use. All quotients come from one iterative divider that the search steps share. A wanted rate that is zero or out of range is refused at once, and the divider is never started for it.

Top module: `i2c_divsrch`

## Requirements
- R1: A request whose target rate is 0 or above 3400 kHz is refused. `done` rises in the cycle after the request with status 1 (range), and `hs_mode`, `timing_word` and `hs_word` are all 0.
- R2: A target above 400 kHz selects high-speed mode (`hs_mode`=1), which limits the step count to 8. A target of 400 kHz or less selects standard/fast mode (`hs_mode`=0) with a step limit of 64.
- R3: The required division is ceil(floor(src/2)/target). Sample counts 1 to 8 are tried in rising order. Each uses step = ceil(division/sample), and a candidate whose step exceeds the mode limit is skipped.
- R4: A candidate replaces the kept pair only when sample×step is strictly smaller, so on a tie the smaller sample count wins. The search ends early once the kept product equals the required division; an exact hit at sample 1 completes in fewer than 4×(SRC_W+2) cycles.
- R5: When no candidate fits, the pair defaults to sample 8 and step equal to the mode limit.
- R6: If floor(src/(2×sample×step)) exceeds the target, status is 2 (unsupported) and all result fields are 0. Otherwise status is 0 (ok).
- R7: In standard/fast mode, `timing_word` holds sample−1 in bits [10:8] and step−1 in bits [5:0]; `hs_word` is 0.
- R8: In high-speed mode, `timing_word` is 0x1303 and `hs_word` holds sample−1 in bits [14:12], step−1 in bits [10:8] and 0x3 in bits [1:0].
- R9: `done` is high for exactly one cycle per accepted request. Status and result fields keep their value until the next `done`.
- R10: A `start` pulse that arrives while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| src_khz | input | SRC_W | Source clock rate in kHz |
| tgt_khz | input | TGT_W | Wanted bus rate in kHz |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 range, 2 unsupported |
| hs_mode | output | 1 | High-speed mode selected |
| timing_word | output | 16 | Standard timing word |
| hs_word | output | 16 | High-speed timing word |

## Verification
A refused request is due exactly one cycle after `start`, so the bench samples it at the very next falling edge. A search takes several divisions of SRC_W+2 cycles each: three for an exact hit at sample 1 and ten for a full sweep. The bench therefore waits for `done` on falling edges and records the count of cycles taken. It compares that count against the early-exit bound and the full-sweep floor. Result fields are read in the `done` cycle and read again several cycles later to confirm they are held.

// File: rtl/i2c_divsrch_pkg.sv
package i2c_divsrch_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_RANGE = 2'd1,
    ST_UNSUP = 2'd2
  } srch_status_e;

  localparam int SMP_MAX      = 8;
  localparam int STEP_FS      = 64;
  localparam int STEP_HS      = 8;
  localparam logic [15:0] HS_TIMING_FIX = 16'h1303;
  localparam logic [1:0]  HS_LOW_BITS   = 2'b11;

  // standard word: sample-1 at [10:8], step-1 at [5:0]
  function automatic logic [15:0] pack_std(input logic [3:0] smp, input logic [6:0] stp);
    logic [2:0] sm;
    logic [5:0] st;
    sm = 3'(smp - 4'd1);
    st = 6'(stp - 7'd1);
    return {5'b0, sm, 2'b0, st};
  endfunction

  // high-speed word: sample-1 at [14:12], step-1 at [10:8], 0x3 low
  function automatic logic [15:0] pack_hs(input logic [3:0] smp, input logic [6:0] stp);
    logic [2:0] sm;
    logic [2:0] st;
    sm = 3'(smp - 4'd1);
    st = 3'(stp - 7'd1);
    return {1'b0, sm, 1'b0, st, 6'b0, HS_LOW_BITS};
  endfunction

  function automatic int mode_limit(input logic hs);
    return hs ? STEP_HS : STEP_FS;
  endfunction

endpackage

// File: rtl/i2c_divsrch_udiv.sv
module i2c_divsrch_udiv #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;

  logic [W:0]    rem_sh, rem_nx;
  logic          fits;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    fits   = rem_sh >= {1'b0, dvs_q};
    rem_nx = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        dvd_q <= dividend;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  // every quotient the search consumes is the true floor quotient (R3)
  assert_quot_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((2*W)'(quotient) * (2*W)'(dvs_q) <= (2*W)'(dvd_q)) &&
             (((2*W)'(quotient) + 1) * (2*W)'(dvs_q) > (2*W)'(dvd_q)));

  // the search never launches a division by zero (R3)
  assert_divisor_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> divisor != '0);

endmodule

// File: rtl/i2c_divsrch_core.sv
module i2c_divsrch_core
  import i2c_divsrch_pkg::*;
#(
  parameter int W          = 20,
  parameter int TGT_W      = 12,
  parameter int FS_MAX_KHZ = 400,
  parameter int HS_MAX_KHZ = 3400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     src_khz,
  input  logic [TGT_W-1:0] tgt_khz,
  output logic             div_go,
  output logic [W-1:0]     div_dvd,
  output logic [W-1:0]     div_dvs,
  input  logic             div_done,
  input  logic [W-1:0]     div_quo,
  output logic             done,
  output logic [1:0]       status,
  output logic             hs_mode,
  output logic [15:0]      timing_word,
  output logic [15:0]      hs_word
);
  localparam int PW = W + 4;

  typedef enum logic [1:0] {S_IDLE, S_MIN, S_STEP, S_VER} srch_state_e;

  srch_state_e  state_q;
  logic [W-1:0] src_q, min_q;
  logic [TGT_W-1:0] tgt_q;
  logic         hs_q;
  logic [6:0]   lim_q;
  logic [3:0]   s_q, best_s_q;
  logic [6:0]   best_st_q;
  logic [PW-1:0] best_prod_q;
  logic         go_q;
  logic [W-1:0] dvd_q, dvs_q;

  logic         done_q, hs_out_q;
  srch_status_e status_q;
  logic [15:0]  tw_q, hw_q;

  // named events for the search step
  logic          req_bad, req_hs;
  logic [PW-1:0] prod_c;
  logic          cand_fits, cand_better, cand_exact, sweep_last;
  logic [3:0]    nb_s;
  logic [6:0]    nb_st;
  logic [W-1:0]  ver_dvs;
  logic          rate_too_high;

  always_comb begin
    req_bad     = (tgt_khz == '0) || (int'(tgt_khz) > HS_MAX_KHZ);
    req_hs      = int'(tgt_khz) > FS_MAX_KHZ;
    prod_c      = PW'(s_q) * {4'b0, div_quo};
    cand_fits   = div_quo <= W'(lim_q);
    cand_better = cand_fits && (prod_c < best_prod_q);
    cand_exact  = cand_better && (prod_c == {4'b0, min_q});
    sweep_last  = cand_exact || (s_q == 4'(SMP_MAX));
    nb_s        = cand_better ? s_q : best_s_q;
    nb_st       = cand_better ? div_quo[6:0] : best_st_q;
    ver_dvs     = W'(2 * int'(nb_s) * int'(nb_st));
    rate_too_high = div_quo > W'(tgt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      src_q       <= '0;
      tgt_q       <= '0;
      min_q       <= '0;
      hs_q        <= 1'b0;
      lim_q       <= '0;
      s_q         <= 4'd1;
      best_s_q    <= 4'd1;
      best_st_q   <= 7'd1;
      best_prod_q <= '0;
      go_q        <= 1'b0;
      dvd_q       <= '0;
      dvs_q       <= '0;
      done_q      <= 1'b0;
      hs_out_q    <= 1'b0;
      status_q    <= ST_OK;
      tw_q        <= '0;
      hw_q        <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            src_q <= src_khz;
            tgt_q <= tgt_khz;
            if (req_bad) begin
              done_q   <= 1'b1;
              status_q <= ST_RANGE;
              hs_out_q <= 1'b0;
              tw_q     <= '0;
              hw_q     <= '0;
            end else begin
              hs_q        <= req_hs;
              lim_q       <= 7'(mode_limit(req_hs));
              best_s_q    <= 4'(SMP_MAX);
              best_st_q   <= 7'(mode_limit(req_hs));
              best_prod_q <= PW'(SMP_MAX * mode_limit(req_hs));
              s_q         <= 4'd1;
              dvd_q       <= (src_khz >> 1) + W'(tgt_khz) - W'(1);
              dvs_q       <= W'(tgt_khz);
              go_q        <= 1'b1;
              state_q     <= S_MIN;
            end
          end
        end
        S_MIN: begin
          if (div_done) begin
            min_q   <= div_quo;
            dvd_q   <= div_quo;
            dvs_q   <= W'(1);
            go_q    <= 1'b1;
            state_q <= S_STEP;
          end
        end
        S_STEP: begin
          if (div_done) begin
            if (cand_better) begin
              best_s_q    <= s_q;
              best_st_q   <= div_quo[6:0];
              best_prod_q <= prod_c;
            end
            go_q <= 1'b1;
            if (sweep_last) begin
              dvd_q   <= src_q;
              dvs_q   <= ver_dvs;
              state_q <= S_VER;
            end else begin
              s_q   <= s_q + 4'd1;
              dvd_q <= min_q + W'(s_q);
              dvs_q <= W'(s_q) + W'(1);
            end
          end
        end
        S_VER: begin
          if (div_done) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
            if (rate_too_high) begin
              status_q <= ST_UNSUP;
              hs_out_q <= 1'b0;
              tw_q     <= '0;
              hw_q     <= '0;
            end else begin
              status_q <= ST_OK;
              hs_out_q <= hs_q;
              tw_q     <= hs_q ? HS_TIMING_FIX : pack_std(best_s_q, best_st_q);
              hw_q     <= hs_q ? pack_hs(best_s_q, best_st_q) : 16'h0;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign div_go      = go_q;
  assign div_dvd     = dvd_q;
  assign div_dvs     = dvs_q;
  assign done        = done_q;
  assign status      = status_q;
  assign hs_mode     = hs_out_q;
  assign timing_word = tw_q;
  assign hs_word     = hw_q;

  assert_range_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start && req_bad) |=> (done && status == 2'd1));

  assert_sample_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STEP) |-> (s_q >= 4'd1 && s_q <= 4'(SMP_MAX)));

  assert_best_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> best_prod_q <= $past(best_prod_q));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(timing_word) && $stable(hs_word) && $stable(status) && $stable(hs_mode)));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start) |=> !done || $past(state_q) == S_VER);

endmodule

// File: rtl/i2c_divsrch.sv
module i2c_divsrch #(
  parameter int SRC_W      = 20,
  parameter int TGT_W      = 12,
  parameter int FS_MAX_KHZ = 400,
  parameter int HS_MAX_KHZ = 3400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SRC_W-1:0] src_khz,
  input  logic [TGT_W-1:0] tgt_khz,
  output logic             done,
  output logic [1:0]       status,
  output logic             hs_mode,
  output logic [15:0]      timing_word,
  output logic [15:0]      hs_word
);
  logic             div_go, div_done;
  logic [SRC_W-1:0] div_dvd, div_dvs, div_quo;

  i2c_divsrch_core #(
    .W(SRC_W), .TGT_W(TGT_W), .FS_MAX_KHZ(FS_MAX_KHZ), .HS_MAX_KHZ(HS_MAX_KHZ)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .src_khz(src_khz), .tgt_khz(tgt_khz),
    .div_go(div_go), .div_dvd(div_dvd), .div_dvs(div_dvs),
    .div_done(div_done), .div_quo(div_quo),
    .done(done), .status(status), .hs_mode(hs_mode),
    .timing_word(timing_word), .hs_word(hs_word)
  );

  i2c_divsrch_udiv #(.W(SRC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dvd), .divisor(div_dvs),
    .done(div_done), .quotient(div_quo)
  );

endmodule

// File: tb/tb_i2c_divsrch.sv
module tb_i2c_divsrch;
  localparam int SRC_W = 20;
  localparam int TGT_W = 12;
  localparam int LAT_MAX = 1000;
  localparam int NV = 11;

  // source, target, status, hs, timing word, hs word (hand-derived from R2..R8)
  localparam int VSRC [NV] = '{26000, 26000, 26000, 26000, 26000, 200000, 200000, 52000, 1000, 64100, 102450};
  localparam int VTGT [NV] = '{100,   400,   401,   1000,  3400,  100,    1000,   100,   400,  500,   100};
  localparam int VST  [NV] = '{0,     0,     0,     0,     0,     2,      2,      0,     0,    0,     0};
  localparam int VHS  [NV] = '{0,     0,     1,     1,     1,     0,      0,      0,     0,    1,     0};
  localparam int VTW  [NV] = '{'h0419,'h0020,'h1303,'h1303,'h1303,0,     0,      'h0433,'h0001,'h1303,'h073F};
  localparam int VHW  [NV] = '{0,     0,     'h4603,'h1603,'h0303,0,     0,      0,     0,    'h7703,0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SRC_W-1:0] src_khz = '0;
  logic [TGT_W-1:0] tgt_khz = '0;
  logic done, hs_mode;
  logic [1:0] status;
  logic [15:0] timing_word, hs_word;

  int checks = 0;
  int errors = 0;
  int lat_fast = 0;
  int lat_full = 0;

  always #10 clk = ~clk;

  i2c_divsrch #(.SRC_W(SRC_W), .TGT_W(TGT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_khz(src_khz), .tgt_khz(tgt_khz),
    .done(done), .status(status), .hs_mode(hs_mode),
    .timing_word(timing_word), .hs_word(hs_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic request(input int src, input int tgt, output int lat);
    @(negedge clk);
    start   = 1'b1;
    src_khz = SRC_W'(src);
    tgt_khz = TGT_W'(tgt);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < LAT_MAX) begin
      @(negedge clk);
      lat++;
    end
    if (!done) check("R9 done timeout", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 reset done", int'(done), 0);
    check("R9 reset status", int'(status), 0);
    check("R9 reset words", int'(timing_word) | int'(hs_word) | int'(hs_mode), 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      request(VSRC[i], VTGT[i], lat);
      check($sformatf("R6 status vec%0d", i), int'(status), VST[i]);
      check($sformatf("R2 hs_mode vec%0d", i), int'(hs_mode), VHS[i]);
      check($sformatf("R7 timing_word vec%0d", i), int'(timing_word), VTW[i]);
      check($sformatf("R8 hs_word vec%0d", i), int'(hs_word), VHW[i]);
      if (i == 1) lat_fast = lat;
      if (i == 2) lat_full = lat;
      @(negedge clk);
      check($sformatf("R9 pulse vec%0d", i), int'(done), 0);
    end

    // early exit on exact hit vs full sweep (R4)
    check("R4 early exit latency", int'(lat_fast < 4 * (SRC_W + 2)), 1);
    check("R3 full sweep latency", int'(lat_full > 9 * (SRC_W + 2)), 1);

    // hold after done (R9)
    repeat (5) @(negedge clk);
    check("R9 held timing", int'(timing_word), 'h073F);
    check("R9 held status", int'(status), 0);

    // range refusals, due one cycle after the request (R1)
    request(26000, 0, lat);
    check("R1 zero target latency", lat, 1);
    check("R1 zero target status", int'(status), 1);
    check("R1 zero target words", int'(timing_word) | int'(hs_word) | int'(hs_mode), 0);
    request(26000, 3401, lat);
    check("R1 3401 status", int'(status), 1);
    check("R1 3401 latency", lat, 1);
    request(26000, 4095, lat);
    check("R1 4095 status", int'(status), 1);

    // start during a search is ignored (R10)
    @(negedge clk);
    start = 1'b1; src_khz = SRC_W'(26000); tgt_khz = TGT_W'(100);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; tgt_khz = '0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10 no early done", int'(done), 0);
    lat = 0;
    while (!done && lat < LAT_MAX) begin
      @(negedge clk);
      lat++;
    end
    check("R10 first request result status", int'(status), 0);
    check("R10 first request result timing", int'(timing_word), 'h0419);
    @(negedge clk);
    check("R10 single done", int'(done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule